// File: doc/BRIEF.md
# Video Sync Conditioner with Field Detector

This block sits at the front of a parallel digital video input port. It takes the raw horizontal and vertical sync lines and samples them on the pixel clock. Each line can be inverted on its own, and the vertical sync can be taken on either edge of the clock. The block presents the cleaned sync levels and a one-clock pulse on each active-high leading edge.

From those leading edges it decides whether the current frame is the top or the bottom field of an interlaced picture. It counts the pixel clocks between the vertical sync leading edge and the nearest horizontal sync leading edge, whichever side that horizontal edge falls on. A distance at or below a programmable 10-bit skew gives a top field. A larger distance gives a bottom field. Each decision raises a one-clock strobe, and the field flag keeps its value until the next decision. Configuration is a set of static inputs that are changed only while reset is held.

Top module: `bt601_field_detect`

## Requirements
- R1: While `rst_n` is low, all outputs (`hs_out`, `vs_out`, `hs_edge`, `vs_edge`, `field_top`, `field_valid`) are 0.
- R2: `hs_out` equals `hs_in` XOR `cfg_hs_inv` as sampled at the previous rising clock edge (1 = invert).
- R3: `vs_out` equals `vs_in` XOR `cfg_vs_inv` (1 = invert), with a one-clock latency from an input change made between a rising edge and the following falling edge.
- R4: When `cfg_vs_fall` is 0, vertical sync is sampled on the rising clock edge. When it is 1, vertical sync is sampled on the falling edge and then re-registered on the next rising edge. A vertical pulse that spans only a falling edge is seen in mode 1 and ignored in mode 0.
- R5: `hs_edge` and `vs_edge` each pulse for exactly one clock when the matching conditioned output goes from 0 to 1. The pulse appears in the same cycle as the new level.
- R6: If `vs_edge` occurs when the last `hs_edge` was at most `cfg_skew` clocks earlier (this includes the same cycle), the field is top. `field_valid` and `field_top` are 1 in the next cycle.
- R7: Otherwise, an `hs_edge` that comes 1 to `cfg_skew` clocks after `vs_edge` gives a top field, reported in the cycle after that `hs_edge`.
- R8: If neither R6 nor R7 applies, the field is bottom. The decision is taken max(`cfg_skew`,1) clocks after `vs_edge`, so `field_valid`=1 and `field_top`=0 one cycle after that.
- R9: Each vertical sync leading edge produces exactly one `field_valid` pulse. `field_top` does not change in any cycle where `field_valid` is 0.
- R10: The count of clocks since the last horizontal edge saturates, and starts saturated after reset. A vertical sync with no horizontal sync since reset is therefore judged bottom, even with `cfg_skew` at its maximum of 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_in | input | 1 | Raw horizontal sync |
| vs_in | input | 1 | Raw vertical sync |
| cfg_skew | input | 10 | Field window, in pixel clocks |
| cfg_hs_inv | input | 1 | Invert horizontal sync when 1 |
| cfg_vs_inv | input | 1 | Invert vertical sync when 1 |
| cfg_vs_fall | input | 1 | Sample vertical sync on the falling edge when 1 |
| hs_out | output | 1 | Conditioned horizontal sync level |
| vs_out | output | 1 | Conditioned vertical sync level |
| hs_edge | output | 1 | One-clock leading-edge pulse of `hs_out` |
| vs_edge | output | 1 | One-clock leading-edge pulse of `vs_out` |
| field_top | output | 1 | 1 = top field, 0 = bottom field |
| field_valid | output | 1 | One-clock strobe on each field decision |

## Verification
The hardest case to reach is the window boundary on both sides of the horizontal edge. The decision flips between top and bottom at exactly one clock offset, and the bottom result is issued by a timeout rather than by any sync edge. The bench sweeps the horizontal-to-vertical offset from -7 to +7 clocks against several skew values and rotates the polarity and sampling-edge settings through the sweep. For every trial it computes both the expected field and the exact cycle of the strobe. The falling-edge path is driven with a sub-cycle vertical pulse that covers only one falling clock edge.

// File: rtl/bt601_field_detect.sv
module bt601_field_detect #(
  parameter int SKEW_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_in,
  input  logic              vs_in,
  input  logic [SKEW_W-1:0] cfg_skew,
  input  logic              cfg_hs_inv,
  input  logic              cfg_vs_inv,
  input  logic              cfg_vs_fall,
  output logic              hs_out,
  output logic              vs_out,
  output logic              hs_edge,
  output logic              vs_edge,
  output logic              field_top,
  output logic              field_valid
);
  localparam int CNT_W = SKEW_W + 1;

  logic             hs_cap, vs_pos, vs_neg, vs_neg_rs;
  logic             hs_prev, vs_prev;
  logic [CNT_W-1:0] hcnt, vcnt;
  logic             pending;

  wire hs_c = hs_in ^ cfg_hs_inv;
  wire vs_c = vs_in ^ cfg_vs_inv;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) vs_neg <= 1'b0;
    else        vs_neg <= vs_c;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hs_cap    <= 1'b0;
      vs_pos    <= 1'b0;
      vs_neg_rs <= 1'b0;
      hs_prev   <= 1'b0;
      vs_prev   <= 1'b0;
    end else begin
      hs_cap    <= hs_c;
      vs_pos    <= vs_c;
      vs_neg_rs <= vs_neg;
      hs_prev   <= hs_out;
      vs_prev   <= vs_out;
    end

  assign hs_out  = hs_cap;
  assign vs_out  = cfg_vs_fall ? vs_neg_rs : vs_pos;
  assign hs_edge = hs_out & ~hs_prev;
  assign vs_edge = vs_out & ~vs_prev;

  wire [CNT_W-1:0] skew  = {1'b0, cfg_skew};
  wire [CNT_W-1:0] hdist = hs_edge ? '0 : hcnt;
  wire vs_top   = vs_edge && (hdist <= skew);
  wire pend_top = pending && !vs_edge && hs_edge && (vcnt <= skew);
  wire pend_bot = pending && !vs_edge && !pend_top && (vcnt >= skew);
  wire decide   = vs_top | pend_top | pend_bot;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hcnt        <= '1;
      vcnt        <= '1;
      pending     <= 1'b0;
      field_top   <= 1'b0;
      field_valid <= 1'b0;
    end else begin
      if (hs_edge)        hcnt <= CNT_W'(1);
      else if (~&hcnt)    hcnt <= hcnt + 1'b1;
      if (vs_edge)        vcnt <= CNT_W'(1);
      else if (~&vcnt)    vcnt <= vcnt + 1'b1;
      pending     <= vs_edge ? !vs_top : (pending && !decide);
      field_valid <= decide;
      if (decide) field_top <= vs_top | pend_top;
    end
endmodule

module bt601_field_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic hs_in,
  input logic cfg_hs_inv,
  input logic hs_out,
  input logic vs_out,
  input logic hs_edge,
  input logic vs_edge,
  input logic field_top,
  input logic field_valid
);
  a_r2_hs_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> hs_out == ($past(hs_in) ^ $past(cfg_hs_inv)));
  a_r5_hs_pulse_one: assert property (@(posedge clk) disable iff (!rst_n)
    hs_edge |=> !hs_edge);
  a_r5_vs_pulse_one: assert property (@(posedge clk) disable iff (!rst_n)
    vs_edge |=> !vs_edge);
  a_r5_edge_level: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_edge |-> hs_out) and (vs_edge |-> vs_out));
  a_r6_top_from_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (field_valid && field_top) |-> $past(hs_edge || vs_edge));
  a_r9_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !field_valid |-> $stable(field_top));
endmodule

bind bt601_field_detect bt601_field_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hs_in(hs_in), .cfg_hs_inv(cfg_hs_inv),
  .hs_out(hs_out), .vs_out(vs_out), .hs_edge(hs_edge), .vs_edge(vs_edge),
  .field_top(field_top), .field_valid(field_valid));

// File: tb/bt601_field_detect_bench.sv
module bt601_field_detect_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hs_in = 1'b0, vs_in = 1'b0;
  logic [9:0] cfg_skew = '0;
  logic       cfg_hs_inv = 1'b0, cfg_vs_inv = 1'b0, cfg_vs_fall = 1'b0;
  logic       hs_out, vs_out, hs_edge, vs_edge, field_top, field_valid;

  int errors = 0, checks = 0, cyc = 0;
  int nvalid = 0, last_cyc = 0, nhs = 0, nvs = 0, hold_bad = 0;
  logic last_top = 1'b0, prev_top = 1'b0;
  logic cond_on = 1'b0, prev_hc = 1'b0, prev_vc = 1'b0;

  bt601_field_detect u_bt601_field_detect (
    .clk(clk), .rst_n(rst_n), .hs_in(hs_in), .vs_in(vs_in), .cfg_skew(cfg_skew),
    .cfg_hs_inv(cfg_hs_inv), .cfg_vs_inv(cfg_vs_inv), .cfg_vs_fall(cfg_vs_fall),
    .hs_out(hs_out), .vs_out(vs_out), .hs_edge(hs_edge), .vs_edge(vs_edge),
    .field_top(field_top), .field_valid(field_valid));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (field_valid) begin nvalid++; last_cyc = cyc; last_top = field_top; end
      else if (field_top != prev_top) hold_bad++;
      if (hs_edge) nhs++;
      if (vs_edge) nvs++;
      if (cond_on) begin
        check(hs_out == prev_hc, "R2", hs_out, prev_hc);
        check(vs_out == prev_vc, "R3", vs_out, prev_vc);
      end
      prev_hc = hs_in ^ cfg_hs_inv;
      prev_vc = vs_in ^ cfg_vs_inv;
    end
    prev_top = field_top;
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic do_reset(input int skew, input bit hinv, input bit vinv, input bit fall);
    cond_on = 1'b0;
    rst_n = 1'b0;
    cfg_skew = 10'(skew); cfg_hs_inv = hinv; cfg_vs_inv = vinv; cfg_vs_fall = fall;
    hs_in = hinv; vs_in = vinv;
    repeat (3) tick();
    check({hs_out, vs_out, hs_edge, vs_edge, field_top, field_valid} == 6'b0,
          "R1", {hs_out, vs_out, hs_edge, vs_edge, field_top, field_valid}, 0);
    rst_n = 1'b1;
    tick();
    nvalid = 0; nhs = 0; nvs = 0; hold_bad = 0;
    cond_on = 1'b1;
  endtask

  task automatic trial(input int skew, input int d, input bit hinv, input bit vinv, input bit fall);
    int base, ch, cv, ad, j, exp_cyc;
    bit exp_top;
    do_reset(skew, hinv, vinv, fall);
    base = cyc;
    ch = base + 10;
    cv = ch + d;
    for (int t = 0; t < 45; t++) begin
      hs_in = ((cyc >= ch) && (cyc < ch + 2)) ^ hinv;
      vs_in = ((cyc >= cv) && (cyc < cv + 3)) ^ vinv;
      tick();
    end
    ad = (d < 0) ? -d : d;
    exp_top = (ad <= skew);
    j = (skew < 1) ? 1 : skew;
    exp_cyc = exp_top ? (((ch > cv) ? ch : cv) + 2) : (cv + 2 + j);
    check(nvalid == 1, exp_top ? ((d >= 0) ? "R6" : "R7") : "R9", nvalid, 1);
    check(last_top == exp_top, exp_top ? ((d >= 0) ? "R6" : "R7") : "R8", last_top, exp_top);
    check(last_cyc == exp_cyc, exp_top ? ((d >= 0) ? "R6" : "R7") : "R8", last_cyc - base, exp_cyc - base);
    check(nhs == 1 && nvs == 1, "R5", nhs * 10 + nvs, 11);
    check(hold_bad == 0, "R9", hold_bad, 0);
  endtask

  task automatic glitch(input bit fall);
    do_reset(4, 1'b0, 1'b0, fall);
    cond_on = 1'b0;
    hs_in = 1'b1; tick(); hs_in = 1'b0; tick();
    @(posedge clk); #3 vs_in = 1'b1; #2 vs_in = 1'b0;
    repeat (20) tick();
    check(nvs == (fall ? 1 : 0), "R4", nvs, fall ? 1 : 0);
    check(nvalid == (fall ? 1 : 0), "R4", nvalid, fall ? 1 : 0);
  endtask

  initial begin
    int sk[4] = '{0, 1, 2, 5};
    int n = 0;
    for (int s = 0; s < 4; s++)
      for (int d = -7; d <= 7; d++) begin
        trial(sk[s], d, n[0], n[1], n[2]);
        n++;
      end
    glitch(1'b0);
    glitch(1'b1);
    begin : r10_no_hsync
      int cv;
      do_reset(1023, 1'b0, 1'b0, 1'b0);
      repeat (5) tick();
      cv = cyc;
      vs_in = 1'b1; repeat (3) tick(); vs_in = 1'b0;
      repeat (1040) tick();
      check(nvalid == 1 && last_top == 1'b0, "R10", nvalid * 10 + last_top, 10);
      check(last_cyc == cv + 2 + 1023, "R10", last_cyc - cv, 1025);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule